// File: doc/BRIEF.md
# DRAM Row/Column Access Sequencer

This block sits between a simple host port and an array of dynamic storage cells arranged as rows of words. Each host request carries one address. The block splits that address into a row and a column. It opens the row with a row strobe, which moves the whole row into a row buffer. It then issues a column strobe to pick one word of that buffer.

Opening a row wipes the cells, just as sensing a charged cell drains it. For that reason every activation ends with a restore phase, which writes the row buffer back into the same row, and then a precharge phase. A refresh timer visits every row once per refresh period. When a refresh falls due, it wins over a waiting host request as soon as the block is idle. A refresh does not interrupt an access that is already under way.

Host requests use a valid/ready handshake. Reads return one full data word, and that word stays on the output until the next request is accepted.

Top module: `dram_row_sequencer`

## Requirements
- R1: The address is split as {row, column}. The upper ROW_W bits of `req_addr` select the row and the lower COL_W bits select the word within the row. `dram_row` and `dram_col` show these values while the column strobe is high.
- R2: The column strobe `dram_cas` is only ever high while the row strobe `dram_ras` is high. `dram_we` is high only during the column phase of a write.
- R3: A read returns the data word most recently written to the same address.
- R4: The row buffer is written back after every activation. Any number of reads and writes to any row leaves the other words of that row unchanged.
- R5: `req_ready` goes low in the cycle after a request is accepted. For an access not followed by a refresh, it stays low for exactly T_RAS+T_CAS+T_RST+T_PRE cycles.
- R6: For a read, `rd_valid` rises and `rd_data` carries the word T_RAS+1 cycles after acceptance. Both hold until the next request is accepted.
- R7: A write never loads `rd_data`. The accepted write clears `rd_valid`, and `rd_data` keeps its previous value.
- R8: With no host traffic, exactly ROWS refresh operations take place in each REF_CYCLES window, and together they cover every row. Refresh is shown by `refresh_o`.
- R9: A refresh never shows a column strobe, and `req_ready` stays low for its whole duration. When a refresh is due it goes ahead of a waiting request, and stored data survives it.
- R10: After reset, `req_ready` is high and `dram_ras`, `dram_cas`, `dram_we`, `rd_valid` and `refresh_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and no refresh due; a request is taken when both are high |
| req_addr | input | ROW_W+COL_W | {row, column} address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data word |
| rd_data | output | DATA_W | Last word read |
| rd_valid | output | 1 | rd_data belongs to the most recent accepted request |
| dram_ras | output | 1 | Row strobe (row open) |
| dram_cas | output | 1 | Column strobe |
| dram_we | output | 1 | Write strobe |
| dram_row | output | ROW_W | Row address on the array |
| dram_col | output | COL_W | Column address on the array |
| refresh_o | output | 1 | A refresh operation is in progress |

## Verification
The assertions assume that the refresh interval, REF_CYCLES divided by ROWS, is longer than one complete host access. If it were not, a refresh tick could arrive while the previous one is still pending. The stimulus keeps to this by using a 250-cycle interval against a 6-cycle access. The assertions also assume that the host holds its address, data and write enable steady until the request is accepted. The driver task drives every field at a falling edge and keeps them unchanged until the accepting edge has passed. Reads only target addresses the bench has already written, so the expected value of every read is defined.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN,
    PH_COL,
    PH_BACK,
    PH_CLOSE
  } phase_t;
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ROW_W    = 3,
  parameter int LINE_W   = 32
) (
  input  logic              clk,
  input  logic              open_en,
  input  logic              back_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [LINE_W-1:0] line_in,
  output logic [LINE_W-1:0] line_out
);
  localparam int NROWS = 1 << ROW_W;

  logic [LINE_W-1:0] cells [NROWS];

  // Sensing a row drains it: the old contents leave, zeros stay behind.
  always_ff @(posedge clk) begin
    if (open_en) begin
      line_out   <= cells[row];
      cells[row] <= '0;
    end else if (back_en) begin
      cells[row] <= line_in;
    end
  end

  // R4: sensing and write-back are never requested together
  a_r4_one_op: assert property (@(posedge clk) !(open_en && back_en));
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int ROW_W    = 3,
  parameter int INTERVAL = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             due,
  output logic [ROW_W-1:0] row
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
      due <= 1'b0;
      row <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick)     due <= 1'b1;
      else if (ack) due <= 1'b0;
      if (ack)      row <= row + 1'b1;
    end
  end

  // R8: a tick never lands on a refresh that is still waiting
  a_r8_no_lost_tick: assert property (@(posedge clk) disable iff (rst) tick |-> !due);
endmodule

// File: rtl/dram_row_sequencer.sv
module dram_row_sequencer
  import dram_seq_pkg::*;
#(
  parameter int ROW_W      = 3,
  parameter int COL_W      = 2,
  parameter int DATA_W     = 8,
  parameter int T_RAS      = 2,
  parameter int T_CAS      = 1,
  parameter int T_RST      = 2,
  parameter int T_PRE      = 1,
  parameter int REF_CYCLES = 2000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic                   dram_ras,
  output logic                   dram_cas,
  output logic                   dram_we,
  output logic [ROW_W-1:0]       dram_row,
  output logic [COL_W-1:0]       dram_col,
  output logic                   refresh_o
);
  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int NCOLS   = 1 << COL_W;
  localparam int LINE_W  = NCOLS * DATA_W;
  localparam int ROWS    = 1 << ROW_W;
  localparam int REF_INT = REF_CYCLES / ROWS;
  localparam int T_MAX1  = (T_RAS > T_CAS) ? T_RAS : T_CAS;
  localparam int T_MAX2  = (T_RST > T_PRE) ? T_RST : T_PRE;
  localparam int T_MAX   = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int PC_W    = $clog2(T_MAX + 1);

  phase_t            phase;
  logic [PC_W-1:0]   pcnt;
  logic [PC_W-1:0]   plen;
  logic              last;
  logic              is_ref, is_wr;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LINE_W-1:0] rbuf;
  logic [LINE_W-1:0] arr_q;
  logic              ref_due, ref_ack;
  logic [ROW_W-1:0]  ref_row;
  logic              accept;

  dram_refresh_timer #(.ROW_W(ROW_W), .INTERVAL(REF_INT)) u_timer (
    .clk (clk), .rst (rst), .ack (ref_ack), .due (ref_due), .row (ref_row)
  );

  dram_cell_array #(.ROW_W(ROW_W), .LINE_W(LINE_W)) u_array (
    .clk      (clk),
    .open_en  (phase == PH_OPEN && pcnt == '0),
    .back_en  (phase == PH_BACK && pcnt == '0),
    .row      (row_q),
    .line_in  (rbuf),
    .line_out (arr_q)
  );

  always_comb begin
    case (phase)
      PH_OPEN:  plen = PC_W'(T_RAS);
      PH_COL:   plen = PC_W'(T_CAS);
      PH_BACK:  plen = PC_W'(T_RST);
      PH_CLOSE: plen = PC_W'(T_PRE);
      default:  plen = PC_W'(1);
    endcase
  end

  assign last      = (pcnt == plen - 1'b1);
  assign req_ready = (phase == PH_IDLE) && !ref_due;
  assign ref_ack   = (phase == PH_IDLE) && ref_due;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      pcnt     <= '0;
      is_ref   <= 1'b0;
      is_wr    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          pcnt <= '0;
          if (ref_ack) begin
            phase  <= PH_OPEN;
            is_ref <= 1'b1;
            is_wr  <= 1'b0;
            row_q  <= ref_row;
          end else if (accept) begin
            phase    <= PH_OPEN;
            is_ref   <= 1'b0;
            is_wr    <= req_we;
            row_q    <= req_addr[ADDR_W-1 -: ROW_W];
            col_q    <= req_addr[COL_W-1:0];
            wdata_q  <= req_wdata;
            rd_valid <= 1'b0;
          end
        end
        default: begin
          if (last) begin
            pcnt <= '0;
            case (phase)
              PH_OPEN:  phase <= is_ref ? PH_BACK : PH_COL;
              PH_COL:   phase <= PH_BACK;
              PH_BACK:  phase <= PH_CLOSE;
              default:  phase <= PH_IDLE;
            endcase
          end else begin
            pcnt <= pcnt + 1'b1;
          end
          if (phase == PH_COL && pcnt == '0 && !is_wr) begin
            rd_data  <= rbuf[int'(col_q)*DATA_W +: DATA_W];
            rd_valid <= 1'b1;
          end
        end
      endcase
    end
  end

  // Row buffer: filled at the end of row open, patched by a write column phase.
  always_ff @(posedge clk) begin
    if (phase == PH_OPEN && last)
      rbuf <= arr_q;
    else if (phase == PH_COL && pcnt == '0 && is_wr)
      rbuf[int'(col_q)*DATA_W +: DATA_W] <= wdata_q;
  end

  assign dram_ras  = (phase == PH_OPEN) || (phase == PH_COL) || (phase == PH_BACK);
  assign dram_cas  = (phase == PH_COL);
  assign dram_we   = (phase == PH_COL) && is_wr;
  assign dram_row  = row_q;
  assign dram_col  = col_q;
  assign refresh_o = is_ref && (phase != PH_IDLE);

  initial begin
    if (T_RAS < 2 || T_CAS < 1 || T_RST < 1 || T_PRE < 1)
      $error("phase lengths out of range");
  end

  // R2: column strobe only inside an open row
  a_r2_cas_in_ras: assert property (@(posedge clk) disable iff (rst) dram_cas |-> dram_ras);
  // R4: a row only closes out of the write-back phase
  a_r4_back_before_close: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras) |-> $past(phase == PH_BACK));
  // R5: accepting a request drops ready
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  // R6: read result held until the next acceptance
  a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !accept) |=> (rd_valid && $stable(rd_data)));
  // R9: refresh never selects a column and never offers ready
  a_r9_refresh_no_col: assert property (@(posedge clk) disable iff (rst)
    refresh_o |-> (!dram_cas && !req_ready));
endmodule

// File: tb/tb_dram_row_sequencer.sv
module tb_dram_row_sequencer;
  localparam int ROW_W = 3, COL_W = 2, DATA_W = 8;
  localparam int T_RAS = 2, T_CAS = 1, T_RST = 2, T_PRE = 1;
  localparam int REF_CYCLES = 2000;
  localparam int ROWS = 1 << ROW_W;
  localparam int BUSY = T_RAS + T_CAS + T_RST + T_PRE;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, req_ready;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rd_data;
  logic rd_valid, dram_ras, dram_cas, dram_we, refresh_o;
  logic [ROW_W-1:0] dram_row;
  logic [COL_W-1:0] dram_col;

  int errors = 0, checks = 0, cycles = 0;
  logic [DATA_W-1:0] model [32];
  logic [DATA_W-1:0] expq [$];
  logic [ROW_W+COL_W-1:0] cur_addr = '0;
  logic prev_rv = 1'b0, prev_ref = 1'b0;
  int ref_starts = 0;
  logic [ROWS-1:0] ref_mask = '0;

  always #5 clk = ~clk;

  dram_row_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .dram_ras(dram_ras),
    .dram_cas(dram_cas), .dram_we(dram_we), .dram_row(dram_row),
    .dram_col(dram_col), .refresh_o(refresh_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pops on each new read result, plus strobe checks.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (rd_valid && !prev_rv) begin
        if (expq.size() == 0) chk(1'b0, "R3 unexpected read", rd_data, 0);
        else begin
          automatic logic [DATA_W-1:0] e = expq.pop_front();
          chk(rd_data == e, "R3 read data", rd_data, e);
        end
      end
      if (dram_cas) begin
        chk(dram_row == cur_addr[ROW_W+COL_W-1 -: ROW_W], "R1 row split", dram_row,
            cur_addr[ROW_W+COL_W-1 -: ROW_W]);
        chk(dram_col == cur_addr[COL_W-1:0], "R1 col split", dram_col, cur_addr[COL_W-1:0]);
        chk(dram_ras, "R2 cas inside ras", dram_ras, 1);
      end
      if (dram_we && !dram_cas) chk(1'b0, "R2 we outside cas", dram_we, 0);
      if (refresh_o) begin
        ref_mask[dram_row] = 1'b1;
        if (dram_cas || req_ready) chk(1'b0, "R9 refresh quiet", {dram_cas, req_ready}, 0);
      end
      if (refresh_o && !prev_ref) ref_starts++;
    end
    prev_rv  = rd_valid;
    prev_ref = refresh_o;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Driver: called at a falling edge, returns at a falling edge with ready high.
  task automatic do_req(input bit we, input logic [4:0] a, input logic [7:0] d);
    int k;
    bit saw_ref;
    int rv_at;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    cur_addr = a;
    if (we) model[a] = d;
    else expq.push_back(model[a]);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; saw_ref = 0; rv_at = 0;
    while (!req_ready) begin
      if (refresh_o) saw_ref = 1;
      if (!we && rd_valid && rv_at == 0) rv_at = k;
      k++;
      @(negedge clk);
    end
    if (!saw_ref) begin
      chk(k - 1 == BUSY, "R5 busy length", k - 1, BUSY);
      if (!we) chk(rv_at == T_RAS + 2, "R6 read timing", rv_at, T_RAS + 2);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !dram_ras && !dram_cas && !dram_we && !rd_valid && !refresh_o,
        "R10 reset state", {req_ready, dram_ras, dram_cas, rd_valid, refresh_o}, 5'b10000);

    // R3 R1: several patterns over rows and columns
    do_req(1, 5'd5, 8'hA5);
    do_req(1, 5'd6, 8'h3C);
    do_req(1, 5'd4, 8'h11);
    do_req(1, 5'd9, 8'hFF);
    do_req(1, 5'd31, 8'h81);
    do_req(1, 5'd0, 8'h5A);
    do_req(0, 5'd5, 8'h00);
    // R6: held while idle
    repeat (3) @(negedge clk);
    chk(rd_valid && rd_data == 8'hA5, "R6 hold idle", rd_data, 8'hA5);
    // R7: write leaves rd_data, clears rd_valid
    do_req(1, 5'd7, 8'h55);
    chk(rd_data == 8'hA5, "R7 data unchanged by write", rd_data, 8'hA5);
    chk(!rd_valid, "R7 valid cleared by write", rd_valid, 0);
    // R4: repeated reads of one row and its neighbours survive restore
    do_req(0, 5'd6, 8'h00);
    do_req(0, 5'd4, 8'h11);
    do_req(0, 5'd5, 8'h00);
    do_req(0, 5'd7, 8'h00);
    do_req(1, 5'd6, 8'hC3);
    do_req(0, 5'd4, 8'h00);
    do_req(0, 5'd6, 8'h00);
    do_req(0, 5'd9, 8'h00);
    do_req(0, 5'd31, 8'h00);
    do_req(0, 5'd0, 8'h00);

    // R8: idle window of one refresh period
    ref_starts = 0; ref_mask = '0;
    repeat (REF_CYCLES) @(negedge clk);
    chk(ref_starts == ROWS, "R8 refresh count", ref_starts, ROWS);
    chk(ref_mask == '1, "R8 rows covered", ref_mask, {ROWS{1'b1}});

    // R9: data survives refreshes; back-to-back stream spans a refresh tick
    ref_starts = 0;
    for (int i = 0; i < 10; i++) begin
      do_req(0, 5'd5, 8'h00);
      do_req(0, 5'd6, 8'h00);
      do_req(0, 5'd9, 8'h00);
      do_req(0, 5'd31, 8'h00);
    end
    chk(ref_starts >= 1, "R9 refresh during stream", ref_starts, 1);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R3 all reads returned", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule